// File: doc/BRIEF.md
# Valid-Bit Tagged Ring FIFO

This block is a single-clock first-in first-out buffer. Its ring holds 512 words of 36 bits in a plain inferred array. Every ring slot has its own occupancy flag, kept in registers next to the array. A write sets the slot's flag, and moving a word out of the ring clears it. Whether the ring can take a word, or has one to give, depends only on the flag under the write pointer or the read pointer. The two pointers are never compared. Both pointers are 9 bits wide and wrap from 511 back to 0.

The producer side uses a valid/ready handshake, and so does the consumer side. The word at the head of the ring is moved into a registered output stage, where it is held until the consumer takes it. Asserting `flush` for one clock discards all contents. The block then runs a clearing pass that wipes one flag per cycle. During that pass `busy` is high and both handshakes are closed. An asynchronous reset starts the same pass.

The controller has two states. `ST_SWEEP` clears one flag per cycle. `ST_RUN` passes data. It has three transitions:
- reset enters `ST_SWEEP`;
- *sweep-done* goes from `ST_SWEEP` to `ST_RUN` once the last slot is wiped, and zeroes both pointers;
- *flush-start* goes from `ST_RUN` to `ST_SWEEP` when `flush` is high on a clock edge.

Top module: `vbr_fifo`

## Requirements
- R1: While reset is held, `busy` is 1, and `in_ready` and `out_valid` are 0. After release, `busy` falls on the 512th rising edge. `in_ready` is then 1 and `out_valid` is 0.
- R2: A word is taken on an edge where `in_valid` and `in_ready` are both 1. A word leaves on an edge where `out_valid` and `out_ready` are both 1. Words leave in the order they were taken, and none is lost or duplicated.
- R3: When a word is written into an empty FIFO, `out_valid` stays 0 for the cycle after the write edge. `out_valid` rises, carrying that word, after the following edge.
- R4: Once `out_valid` is 1, it stays 1 and `out_data` stays unchanged until the word is taken, unless a flush occurs.
- R5: `in_ready` is 0 exactly when the slot under the write pointer is flagged. With the consumer stalled, 513 words are taken (512 in the ring plus 1 in the output stage). Further offered words are ignored.
- R6: `out_valid` is 0 when the output stage is empty and the slot under the read pointer is unflagged. Only flagged slots are moved out.
- R7: If `flush` is 1 on an edge in `ST_RUN`, `busy` is 1 for exactly 512 cycles, and `in_ready` and `out_valid` stay 0 throughout. A `flush` raised during the pass has no effect on its length.
- R8: A flush discards every stored word. At *sweep-done* both pointers are 0, and the next written word is the next word read.
- R9: The pointers wrap from 511 to 0, and ordering holds across the wrap.
- R10: A write and a move-out can happen on the same edge, always on different slots. With the producer and consumer both streaming, one word passes per cycle. In a full FIFO, the edge that takes the output word frees a slot, and `in_ready` is 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; starts a clearing pass |
| flush | input | 1 | Synchronous discard request |
| in_valid | input | 1 | Producer offers `in_data` |
| in_ready | output | 1 | FIFO can take a word |
| in_data | input | 36 | Word offered by the producer |
| out_valid | output | 1 | `out_data` holds a word |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | 36 | Word presented to the consumer |
| busy | output | 1 | Clearing pass in progress |

## Verification
A flag set by the producer and a flag clear by the move-out into the output stage can land on the same edge. The design relies on these two never touching the same slot. The bench provokes this in two ways. First, it streams with both handshakes open for over 700 cycles, so the pointers wrap while writes and reads coincide every cycle. Second, it fills the FIFO to 513 words and then takes one word while still offering input. It judges that no input is taken on that edge, that `in_ready` returns one cycle later, and that the drained sequence matches its own queue exactly.

// File: rtl/vbr_pkg.sv
`timescale 1ns/1ps
package vbr_pkg;
    typedef enum logic {
        ST_SWEEP = 1'b0,
        ST_RUN   = 1'b1
    } vbr_state_e;
endpackage

// File: rtl/vbr_flag_bank.sv
`timescale 1ns/1ps
module vbr_flag_bank #(
    parameter int DEPTH = 512,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic [AW-1:0] set_idx,
    input  logic          clr_en,
    input  logic [AW-1:0] clr_idx,
    input  logic          wipe_en,
    input  logic [AW-1:0] wipe_idx,
    output logic          flag_at_wr,
    output logic          flag_at_rd
);
    logic [DEPTH-1:0] flags;

    // Flags carry no reset wiring; the clearing pass owns their initial value.
    always_ff @(posedge clk) begin
        if (wipe_en) begin
            flags[wipe_idx] <= 1'b0;
        end else begin
            if (set_en) flags[set_idx] <= 1'b1;
            if (clr_en) flags[clr_idx] <= 1'b0;
        end
    end

    assign flag_at_wr = flags[set_idx];
    assign flag_at_rd = flags[clr_idx];

    a_r5_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |-> !flags[set_idx]);
    a_r6_clear_only_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |-> flags[clr_idx]);
    a_r10_distinct_slots: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && clr_en) |-> (set_idx != clr_idx));
endmodule

// File: rtl/vbr_store.sv
`timescale 1ns/1ps
module vbr_store #(
    parameter int DEPTH = 512,
    parameter int WIDTH = 36,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/vbr_ctrl.sv
`timescale 1ns/1ps
module vbr_ctrl
    import vbr_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          in_valid,
    input  logic          out_ready,
    input  logic          flag_at_wr,
    input  logic          flag_at_rd,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic          push,
    output logic          pop,
    output logic          wipe_en,
    output logic [AW-1:0] wipe_idx,
    output logic          in_ready,
    output logic          out_valid,
    output logic          busy
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    vbr_state_e    state;
    logic [AW-1:0] sweep_idx;
    logic          out_full;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    // State register, sweep counter, pointers, output-stage occupancy
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_SWEEP;
            sweep_idx <= '0;
            wr_ptr    <= '0;
            rd_ptr    <= '0;
            out_full  <= 1'b0;
        end else begin
            unique case (state)
                ST_SWEEP: begin
                    out_full <= 1'b0;
                    if (sweep_idx == LAST) begin
                        state     <= ST_RUN;   // sweep-done
                        sweep_idx <= '0;
                        wr_ptr    <= '0;
                        rd_ptr    <= '0;
                    end else begin
                        sweep_idx <= sweep_idx + 1'b1;
                    end
                end
                ST_RUN: begin
                    if (flush) begin
                        state     <= ST_SWEEP; // flush-start
                        sweep_idx <= '0;
                        out_full  <= 1'b0;
                    end else begin
                        if (push) wr_ptr <= ptr_next(wr_ptr);
                        if (pop)  rd_ptr <= ptr_next(rd_ptr);
                        if (pop)
                            out_full <= 1'b1;
                        else if (out_valid && out_ready)
                            out_full <= 1'b0;
                    end
                end
                default: state <= ST_SWEEP;
            endcase
        end
    end

    // Outputs decoded from state
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        pop       = 1'b0;
        wipe_en   = 1'b0;
        busy      = 1'b0;
        wipe_idx  = sweep_idx;
        unique case (state)
            ST_SWEEP: begin
                wipe_en = 1'b1;
                busy    = 1'b1;
            end
            ST_RUN: begin
                in_ready  = !flush && !flag_at_wr;
                out_valid = !flush && out_full;
                pop       = !flush && flag_at_rd && (!out_full || out_ready);
            end
            default: busy = 1'b1;
        endcase
        push = in_valid && in_ready;
    end

    a_r7_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!in_ready && !out_valid));
    a_r8_ptrs_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (wr_ptr == '0 && rd_ptr == '0));
    a_r9_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (push && wr_ptr == LAST) |=> (wr_ptr == '0));
endmodule

// File: rtl/vbr_fifo.sv
`timescale 1ns/1ps
module vbr_fifo #(
    parameter int DEPTH = 512,
    parameter int WIDTH = 36
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [WIDTH-1:0] in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [WIDTH-1:0] out_data,
    output logic             busy
);
    localparam int AW = $clog2(DEPTH);

    logic [AW-1:0] wr_ptr, rd_ptr, wipe_idx;
    logic          push, pop, wipe_en, flag_at_wr, flag_at_rd;

    vbr_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .in_valid(in_valid), .out_ready(out_ready),
        .flag_at_wr(flag_at_wr), .flag_at_rd(flag_at_rd),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .push(push), .pop(pop),
        .wipe_en(wipe_en), .wipe_idx(wipe_idx),
        .in_ready(in_ready), .out_valid(out_valid), .busy(busy)
    );

    vbr_flag_bank #(.DEPTH(DEPTH), .AW(AW)) u_flags (
        .clk(clk), .rst_n(rst_n),
        .set_en(push), .set_idx(wr_ptr),
        .clr_en(pop), .clr_idx(rd_ptr),
        .wipe_en(wipe_en), .wipe_idx(wipe_idx),
        .flag_at_wr(flag_at_wr), .flag_at_rd(flag_at_rd)
    );

    vbr_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_store (
        .clk(clk), .we(push), .waddr(wr_ptr), .wdata(in_data),
        .re(pop), .raddr(rd_ptr), .rdata(out_data)
    );

    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> ((out_valid && $stable(out_data)) || flush));
endmodule

// File: tb/sim_vbr_fifo.sv
`timescale 1ns/1ps
module sim_vbr_fifo;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [35:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [35:0] out_data;
    logic        busy;

    int          n_chk = 0;
    int          n_fail = 0;
    logic        acc_in, acc_out;
    logic [35:0] model [$];

    always #10 clk = ~clk;  // 50 MHz

    vbr_fifo u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .busy(busy)
    );

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one cycle; record handshakes; returns at the next falling edge.
    task automatic step(input logic iv, input logic [35:0] d, input logic ordy, input logic fl);
        logic [35:0] exp;
        in_valid = iv; in_data = d; out_ready = ordy; flush = fl;
        #1;
        acc_in  = in_valid && in_ready;
        acc_out = out_valid && out_ready;
        if (acc_out) begin
            if (model.size() == 0) begin
                chk(1'b0, "R2 unexpected word", 64'(out_data), 64'h0);
            end else begin
                exp = model.pop_front();
                chk(out_data == exp, "R2 order", 64'(out_data), 64'(exp));
            end
        end
        if (acc_in) model.push_back(d);
        @(negedge clk);
    endtask

    task automatic drain();
        for (int i = 0; i < 600 && model.size() != 0; i++) step(1'b0, '0, 1'b1, 1'b0);
        chk(model.size() == 0, "R2 drain complete", 64'(model.size()), 64'h0);
        step(1'b0, '0, 1'b1, 1'b0);
        chk(out_valid == 1'b0, "R6 empty after drain", 64'(out_valid), 64'h0);
    endtask

    task automatic t_reset();
        int n;
        repeat (3) @(negedge clk);
        chk(busy == 1'b1, "R1 busy in reset", 64'(busy), 64'h1);
        chk(in_ready == 1'b0 && out_valid == 1'b0, "R1 closed in reset", 64'({in_ready, out_valid}), 64'h0);
        rst_n = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (busy && n < 2000);
        chk(n == 512, "R1 sweep length", 64'(n), 64'd512);
        chk(in_ready == 1'b1 && out_valid == 1'b0, "R1 ready after sweep", 64'({in_ready, out_valid}), 64'h2);
    endtask

    task automatic t_latency_hold();
        step(1'b1, 36'hA_5A5A_0001, 1'b0, 1'b0);
        chk(acc_in == 1'b1, "R2 word taken", 64'(acc_in), 64'h1);
        chk(out_valid == 1'b0, "R3 not yet valid", 64'(out_valid), 64'h0);
        step(1'b0, '0, 1'b0, 1'b0);
        chk(out_valid == 1'b1 && out_data == 36'hA_5A5A_0001, "R3 valid next cycle", 64'(out_data), 64'hA_5A5A_0001);
        step(1'b1, 36'h3_0000_0002, 1'b0, 1'b0);
        for (int i = 0; i < 5; i++) begin
            step(1'b0, '0, 1'b0, 1'b0);
            chk(out_valid == 1'b1 && out_data == 36'hA_5A5A_0001, "R4 held while stalled", 64'(out_data), 64'hA_5A5A_0001);
        end
        step(1'b0, '0, 1'b1, 1'b0);
        chk(out_valid == 1'b1 && out_data == 36'h3_0000_0002, "R4 next word after take", 64'(out_data), 64'h3_0000_0002);
        drain();
    endtask

    task automatic t_fill_full();
        int taken = 0;
        for (int i = 0; i < 530; i++) begin
            step(1'b1, 36'(36'h1_0000_0000 + i), 1'b0, 1'b0);
            if (acc_in) taken++;
        end
        chk(taken == 513, "R5 capacity", 64'(taken), 64'd513);
        chk(in_ready == 1'b0, "R5 ready low when full", 64'(in_ready), 64'h0);
        step(1'b1, 36'hF_FFFF_FFFF, 1'b1, 1'b0);
        chk(acc_out == 1'b1 && acc_in == 1'b0, "R10 take at full, no write", 64'({acc_out, acc_in}), 64'h2);
        chk(in_ready == 1'b1, "R10 slot freed next cycle", 64'(in_ready), 64'h1);
        drain();
    endtask

    task automatic t_stream();
        int outs = 0;
        int stalls = 0;
        for (int i = 0; i < 720; i++) begin
            step(1'b1, 36'(36'h2_0000_0000 + i), 1'b1, 1'b0);
            if (!acc_in) stalls++;
            if (acc_out) outs++;
        end
        chk(stalls == 0, "R10 producer never stalled", 64'(stalls), 64'h0);
        chk(outs == 718, "R10 one word per cycle", 64'(outs), 64'd718);
        drain();
        chk(outs + 2 > 512, "R9 wrap covered", 64'(outs), 64'd512);
    endtask

    task automatic t_flush();
        int n;
        int bad = 0;
        for (int i = 0; i < 5; i++) step(1'b1, 36'(36'h7_0000_0000 + i), 1'b0, 1'b0);
        step(1'b1, 36'hE_EEEE_EEEE, 1'b0, 1'b1);
        chk(acc_in == 1'b0, "R7 no write with flush", 64'(acc_in), 64'h0);
        model.delete();
        chk(busy == 1'b1, "R7 busy after flush", 64'(busy), 64'h1);
        n = 0;
        while (busy && n < 2000) begin
            flush = (n == 100);
            in_valid = 1'b1; out_ready = 1'b1;
            #1;
            if (in_ready || out_valid) bad++;
            @(negedge clk);
            n++;
        end
        chk(n == 512, "R7 sweep length, mid-sweep flush ignored", 64'(n), 64'd512);
        chk(bad == 0, "R7 handshakes closed", 64'(bad), 64'h0);
        step(1'b0, '0, 1'b1, 1'b0);
        chk(out_valid == 1'b0, "R8 contents discarded", 64'(out_valid), 64'h0);
        step(1'b1, 36'hC_0FFE_E123, 1'b1, 1'b0);
        step(1'b0, '0, 1'b1, 1'b0);
        chk(out_valid == 1'b1 && out_data == 36'hC_0FFE_E123, "R8 fresh word after sweep", 64'(out_data), 64'hC_0FFE_E123);
        drain();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_latency_hold();
        t_fill_full();
        t_stream();
        t_flush();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule